// File: doc/BRIEF.md
# Serial Configuration-Flash Command Engine

This block lets a host processor run one serial flash transaction at a time through a small byte-wide register window. The host loads a 16-bit serial clock count, a command byte, three address bytes and up to a page of outgoing data. It then writes a start code, and the engine plays the transaction out on a four-wire SPI link (mode 0) while a busy flag is raised.

The engine does not store any command timing itself. It works out what goes on the wire from the command value and the host's clock count. The command byte is always sent first. Three address bytes follow only for the array read (0xC0) and page program (0x40) commands. On the array read, status read (0xA0) and identification read (0xD5) commands, every clock after that header samples MISO into a capture buffer. On all other commands, the clocks after the header carry bytes from the outgoing buffer. Each byte travels least significant bit first, so the host loads bytes already bit-reversed.

Registers sit on an 8-byte stride. The address bits below the stride only matter for the busy byte at offset 0x01. Writes are accepted only at aligned offsets.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Writes at aligned offsets 0x00 and 0x08 set the high and low bytes of the clock count. Offset 0x10 sets the command. Offsets 0x18, 0x20 and 0x28 set the three address bytes, sent in that order. Only the value 0xFF written at offset 0x7F8 starts a transaction, and any other value there is ignored.
- R2: Reading offset 0x01 returns 0x01 from the cycle after the start is taken until the last clock completes, and 0x00 otherwise.
- R3: Chip select stays low for exactly the programmed number of SCK rising edges. SCK idles low and has a period of SCK_DIV system clocks. MOSI never changes on an SCK rising edge.
- R4: The first eight bits on MOSI are the command register, bit 0 first.
- R5: For commands 0xC0 and 0x40 only, bits 8 to 31 carry the address registers in the order 0x18, 0x20, 0x28, each bit 0 first.
- R6: On commands that are not read-type, each bit after the header carries outgoing byte i (written at 0x30+8*i) bit 0 first. Bytes at i at or beyond OUT_DEPTH are not stored, and they go out as zero.
- R7: On read-type commands (0xC0, 0xA0, 0xD5), MOSI is low after the header. MISO bits are packed bit 0 first into bytes, and byte i reads back at 0x38+8*i. Indices at or beyond IN_DEPTH read back zero.
- R8: Reading offset 0x20 returns the first byte captured after the header.
- R9: A start written while a transaction runs is ignored. Chip select falls once, and the clock count is unchanged.
- R10: Register writes during a transaction are ignored. Neither the running transaction nor the next one triggered without reloading is affected.
- R11: A start with a clock count of zero is ignored, and chip select stays high.
- R12: After reset, chip select is high, SCK and MOSI are low, and the busy byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, valid one cycle after reg_addr |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with SCK_DIV=4 and OUT_DEPTH and IN_DEPTH both set to 8. Each serial bit then lasts four system clocks, so a single run can hold many transactions. The small depths let ten-byte page programs and ten-byte array reads reach past the end of both buffers. That exercises the zero fill on the wire and the zero readback. A bench-side slave records MOSI and feeds known MISO bytes, so the command, address and data ordering can all be compared bit by bit.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [7:0] OP_ARRAY_RD = 8'hC0;
  localparam logic [7:0] OP_PAGE_PRG = 8'h40;
  localparam logic [7:0] OP_STAT_RD  = 8'hA0;
  localparam logic [7:0] OP_IDENT_RD = 8'hD5;

  // address phase present on the wire
  function automatic logic op_has_addr(input logic [7:0] op);
    return (op == OP_ARRAY_RD) || (op == OP_PAGE_PRG);
  endfunction

  // post-header clocks capture MISO
  function automatic logic op_captures(input logic [7:0] op);
    return (op == OP_ARRAY_RD) || (op == OP_STAT_RD) || (op == OP_IDENT_RD);
  endfunction
endpackage

// File: rtl/sflash_regs.sv
module sflash_regs #(
  parameter int ADDR_W    = 11,
  parameter int OUT_DEPTH = 128,
  parameter int IN_DEPTH  = 247,
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int IN_AW    = $clog2(IN_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  output logic              start,
  output logic [15:0]       cnt,
  output logic [7:0]        cmd,
  output logic [7:0]        a_hi,
  output logic [7:0]        a_mid,
  output logic [7:0]        a_lo,
  input  logic [OUT_AW-1:0] out_ridx,
  output logic [7:0]        out_q,
  input  logic              cap_we,
  input  logic [IN_AW-1:0]  cap_idx,
  input  logic [7:0]        cap_data
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam logic [SLOT_W-1:0] S_CNT_HI = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] S_CNT_LO = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_CMD    = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_A_HI   = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] S_A_MID  = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] S_A_LO   = SLOT_W'(5);
  localparam logic [SLOT_W-1:0] S_OUT0   = SLOT_W'(6);
  localparam logic [SLOT_W-1:0] S_IN0    = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] S_TRIG   = '1;
  localparam logic [SLOT_W-1:0] OUT_LIM  = SLOT_W'(OUT_DEPTH);
  localparam logic [SLOT_W-1:0] IN_LIM   = SLOT_W'(IN_DEPTH);

  logic              aligned;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] woff;
  logic [SLOT_W-1:0] roff;
  logic              wr_ok;
  logic              out_wr;
  logic              in_hit;
  logic [IN_AW-1:0]  in_ridx;
  logic [1:0]        rsel;
  logic [7:0]        in_q;

  logic [7:0] out_mem [OUT_DEPTH];
  logic [7:0] in_mem  [IN_DEPTH];

  assign aligned = (reg_addr[2:0] == 3'd0);
  assign slot    = reg_addr[ADDR_W-1:3];
  assign woff    = slot - S_OUT0;
  assign roff    = slot - S_IN0;
  assign wr_ok   = reg_we && aligned && !busy;
  assign out_wr  = wr_ok && (slot >= S_OUT0) && (woff < OUT_LIM);
  assign in_hit  = aligned && ((slot == S_A_MID) || ((slot >= S_IN0) && (roff < IN_LIM)));
  assign in_ridx = (slot == S_A_MID) ? '0 : roff[IN_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmd   <= '0;
      a_hi  <= '0;
      a_mid <= '0;
      a_lo  <= '0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (wr_ok) begin
        unique case (slot)
          S_CNT_HI: cnt[15:8] <= reg_wdata;
          S_CNT_LO: cnt[7:0]  <= reg_wdata;
          S_CMD:    cmd       <= reg_wdata;
          S_A_HI:   a_hi      <= reg_wdata;
          S_A_MID:  a_mid     <= reg_wdata;
          S_A_LO:   a_lo      <= reg_wdata;
          S_TRIG:   start     <= (reg_wdata == 8'hFF);
          default: ;
        endcase
      end
    end
  end

  // outgoing buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (out_wr) out_mem[woff[OUT_AW-1:0]] <= reg_wdata;
    out_q <= out_mem[out_ridx];
  end

  // capture buffer: engine writes, host reads
  always_ff @(posedge clk) begin
    if (cap_we) in_mem[cap_idx] <= cap_data;
    in_q <= in_mem[in_ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) rsel <= 2'd0;
    else if (in_hit) rsel <= 2'd2;
    else if ((reg_addr == ADDR_W'(1)) && busy) rsel <= 2'd1;
    else rsel <= 2'd0;
  end

  assign reg_rdata = (rsel == 2'd2) ? in_q : ((rsel == 2'd1) ? 8'h01 : 8'h00);

  // R10: configuration frozen while a transaction runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({cnt, cmd, a_hi, a_mid, a_lo}));
  // R9: no start pulse produced while busy
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !start);
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter
  import sflash_pkg::*;
#(
  parameter int SCK_DIV   = 4,
  parameter int OUT_DEPTH = 128,
  parameter int IN_DEPTH  = 247,
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int IN_AW    = $clog2(IN_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       cnt,
  input  logic [7:0]        cmd,
  input  logic [7:0]        a_hi,
  input  logic [7:0]        a_mid,
  input  logic [7:0]        a_lo,
  input  logic [7:0]        out_q,
  input  logic              miso,
  output logic [OUT_AW-1:0] out_ridx,
  output logic              cap_we,
  output logic [IN_AW-1:0]  cap_idx,
  output logic [7:0]        cap_data,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi
);
  localparam int HALF  = SCK_DIV / 2;
  localparam int DIV_W = $clog2(HALF + 1);
  localparam logic [DIV_W-1:0] HALF_M1 = DIV_W'(HALF - 1);
  localparam logic [15:0] OUT_LIM = 16'(OUT_DEPTH);
  localparam logic [15:0] IN_LIM  = 16'(IN_DEPTH);

  logic [15:0]      bit_n, nxt, total_q, hdr, d_nxt, d_cur, rise_cnt;
  logic [7:0]       cmd_q, rx_sr, rx_nxt;
  logic [23:0]      addr_q;
  logic [DIV_W-1:0] div_cnt;
  logic             use_addr, rd_type, out_ok_d, out_ok_q, cap_hit, nxt_bit;

  assign use_addr = op_has_addr(cmd_q);
  assign rd_type  = op_captures(cmd_q);
  assign hdr      = use_addr ? 16'd32 : 16'd8;
  assign nxt      = bit_n + 16'd1;
  assign d_nxt    = (nxt - hdr) >> 3;
  assign d_cur    = (bit_n - hdr) >> 3;
  assign out_ridx = d_nxt[OUT_AW-1:0];
  assign out_ok_d = (nxt >= hdr) && (d_nxt < OUT_LIM);
  assign rx_nxt   = {miso, rx_sr[7:1]};
  assign cap_hit  = rd_type && (bit_n >= hdr) && (bit_n[2:0] == 3'd7) && (d_cur < IN_LIM);

  always_comb begin
    if (nxt < 16'd8) nxt_bit = cmd_q[nxt[2:0]];
    else if (use_addr && (nxt < 16'd32)) begin
      unique case (nxt[4:3])
        2'd1:    nxt_bit = addr_q[16 + int'(nxt[2:0])];
        2'd2:    nxt_bit = addr_q[8 + int'(nxt[2:0])];
        default: nxt_bit = addr_q[int'(nxt[2:0])];
      endcase
    end else if (rd_type) nxt_bit = 1'b0;
    else nxt_bit = out_ok_q & out_q[nxt[2:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sck <= 1'b0; cs_n <= 1'b1; mosi <= 1'b0;
      bit_n <= '0; total_q <= '0; cmd_q <= '0; addr_q <= '0;
      div_cnt <= '0; rx_sr <= '0; cap_we <= 1'b0; cap_idx <= '0;
      cap_data <= '0; out_ok_q <= 1'b0; rise_cnt <= '0;
    end else begin
      cap_we   <= 1'b0;
      out_ok_q <= out_ok_d;
      if (!busy) begin
        if (start && (cnt != 16'd0)) begin
          busy <= 1'b1; cs_n <= 1'b0; sck <= 1'b0; bit_n <= '0;
          div_cnt <= '0; total_q <= cnt; cmd_q <= cmd;
          addr_q <= {a_hi, a_mid, a_lo}; mosi <= cmd[0]; rise_cnt <= '0;
        end
      end else if (div_cnt == HALF_M1) begin
        div_cnt <= '0;
        if (!sck) begin
          sck      <= 1'b1;
          rx_sr    <= rx_nxt;
          rise_cnt <= rise_cnt + 16'd1;
          if (cap_hit) begin
            cap_we   <= 1'b1;
            cap_idx  <= d_cur[IN_AW-1:0];
            cap_data <= rx_nxt;
          end
        end else begin
          sck <= 1'b0;
          if (bit_n == total_q - 16'd1) begin
            busy <= 1'b0; cs_n <= 1'b1; mosi <= 1'b0;
          end else begin
            bit_n <= nxt;
            mosi  <= nxt_bit;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R3: exactly the programmed number of rising edges per transaction
  p_cs_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (rise_cnt == total_q));
  // R3: MOSI holds across a rising SCK edge
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  // R12: serial lines idle when not busy
  p_idle_lines_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck));
  // R9: a start during a transaction leaves it untouched
  p_retrig_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(total_q) && $stable(cmd_q)));
  // R11: zero count never starts
  p_zero_cnt_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (cnt == 16'd0)) |=> !busy);
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine #(
  parameter int ADDR_W    = 11,
  parameter int SCK_DIV   = 4,
  parameter int OUT_DEPTH = 128,
  parameter int IN_DEPTH  = 247
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int OUT_AW = $clog2(OUT_DEPTH);
  localparam int IN_AW  = $clog2(IN_DEPTH);

  logic              busy, start, cap_we;
  logic [15:0]       cnt;
  logic [7:0]        cmd, a_hi, a_mid, a_lo, out_q, cap_data;
  logic [OUT_AW-1:0] out_ridx;
  logic [IN_AW-1:0]  cap_idx;

  sflash_regs #(.ADDR_W(ADDR_W), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .start(start),
    .cnt(cnt), .cmd(cmd), .a_hi(a_hi), .a_mid(a_mid), .a_lo(a_lo),
    .out_ridx(out_ridx), .out_q(out_q), .cap_we(cap_we), .cap_idx(cap_idx),
    .cap_data(cap_data)
  );

  sflash_shifter #(.SCK_DIV(SCK_DIV), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_shift (
    .clk(clk), .rst(rst), .start(start), .cnt(cnt), .cmd(cmd), .a_hi(a_hi),
    .a_mid(a_mid), .a_lo(a_lo), .out_q(out_q), .miso(miso), .out_ridx(out_ridx),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data), .busy(busy),
    .sck(sck), .cs_n(cs_n), .mosi(mosi)
  );
endmodule

// File: tb/sflash_cmd_engine_bench.sv
module sflash_cmd_engine_bench;
  localparam int AW = 11, DIV = 4, OUTD = 8, IND = 8;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, miso = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sck, cs_n, mosi;

  always #10 clk = ~clk;

  sflash_cmd_engine #(.ADDR_W(AW), .SCK_DIV(DIV), .OUT_DEPTH(OUTD), .IN_DEPTH(IND)) u_sflash_cmd_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int total = 0, bad = 0;
  int rises = 0, csfalls = 0;
  logic mlog [256];
  logic [7:0] resp [16];
  logic [7:0] omodel [16];
  logic [7:0] e_cmd;
  logic [23:0] e_addr;

  // bench flash model
  always @(negedge cs_n) begin csfalls++; miso <= resp[0][0]; end
  always @(posedge sck) if (!cs_n) begin mlog[rises & 255] = mosi; rises++; end
  always @(negedge sck) if (!cs_n) miso <= (rises < 128) ? resp[rises >> 3][rises & 7] : 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = AW'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); reg_addr = AW'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic bit is_addr(input logic [7:0] c);
    return c == 8'hC0 || c == 8'h40;
  endfunction
  function automatic bit is_rd(input logic [7:0] c);
    return c == 8'hC0 || c == 8'hA0 || c == 8'hD5;
  endfunction

  function automatic logic ebit(input int k);
    int h = is_addr(e_cmd) ? 32 : 8;
    if (k < 8) return e_cmd[k];
    if (is_addr(e_cmd) && k < 32) return e_addr[8*(3 - k/8) + k%8];
    if (is_rd(e_cmd)) return 1'b0;
    return ((k - h)/8 < OUTD) ? omodel[(k - h)/8][k%8] : 1'b0;
  endfunction

  task automatic setup(input logic [7:0] c, input logic [23:0] a, input int n);
    e_cmd = c; e_addr = a;
    wr(8'h00, n >> 8); wr(8'h08, n & 255); wr(8'h10, c);
    wr(8'h18, a[23:16]); wr(8'h20, a[15:8]); wr(8'h28, a[7:0]);
  endtask

  task automatic wait_idle();
    logic [7:0] b;
    for (int i = 0; i < 3000; i++) begin rd(1, b); if (b == 0) return; end
    chk(0, "R2 stuck busy", 1, 0);
  endtask

  task automatic run(input int n, input string tag);
    logic [7:0] b;
    rises = 0; csfalls = 0;
    wr(11'h7F8, 8'hFF);
    @(negedge clk);
    rd(1, b); chk(b == 8'h01, {tag, " R2 busy"}, b, 1);
    wait_idle();
    chk(rises == n, {tag, " R3 clocks"}, rises, n);
    chk(csfalls == 1, {tag, " R3 cs"}, csfalls, 1);
  endtask

  task automatic cmp_wire(input int n, input string tag);
    int miss = 0;
    for (int k = 0; k < n && k < 256; k++) if (mlog[k] !== ebit(k)) miss++;
    chk(miss == 0, {tag, " R4 R5 R6 mosi bits"}, miss, 0);
  endtask

  task automatic cmp_cap(input int nb, input string tag);
    logic [7:0] b;
    int h = is_addr(e_cmd) ? 4 : 1;
    for (int d = 0; d < nb; d++) begin
      rd(8'h38 + 8*d, b);
      chk(b == ((d < IND) ? resp[h + d] : 8'h00), {tag, " R7 capture"}, b, (d < IND) ? resp[h + d] : 0);
    end
  endtask

  task automatic load_out(input int nb);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] v = 8'($urandom);
      if (i < 16) omodel[i] = v;
      wr(8'h30 + 8*i, v);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) begin resp[i] = 8'($urandom); omodel[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R12 idle lines", {cs_n, sck, mosi}, 3'b100);
    rd(1, b); chk(b == 0, "R12 busy reset", b, 0);

    // R11 zero count, R1 non-FF start value
    setup(8'h60, 24'h0, 0); rises = 0; csfalls = 0;
    wr(11'h7F8, 8'hFF); repeat (20) @(negedge clk);
    chk(csfalls == 0, "R11 zero count", csfalls, 0);
    setup(8'h60, 24'h0, 8);
    wr(11'h7F8, 8'h7E); repeat (20) @(negedge clk);
    chk(csfalls == 0, "R1 bad start code", csfalls, 0);

    // R8 status read
    setup(8'hA0, 24'h0, 16); run(16, "status"); cmp_wire(16, "status");
    rd(8'h20, b); chk(b == resp[1], "R8 status at 0x20", b, resp[1]);
    cmp_cap(1, "status");

    // R6 page program past buffer end
    setup(8'h40, 24'hA5_3C_0F, 112); load_out(10); run(112, "page10"); cmp_wire(112, "page10");

    // R7 array read past capture end
    setup(8'hC0, 24'h12_34_56, 112); run(112, "read10"); cmp_wire(112, "read10"); cmp_cap(10, "read10");

    // R9 restart while busy, R10 writes while busy
    setup(8'hD5, 24'h0, 40);
    rises = 0; csfalls = 0;
    wr(11'h7F8, 8'hFF); repeat (10) @(negedge clk);
    wr(11'h7F8, 8'hFF); wr(8'h10, 8'h60); wr(8'h08, 8'h08);
    wait_idle();
    chk(rises == 40 && csfalls == 1, "R9 restart ignored", rises, 40);
    cmp_wire(40, "ident"); cmp_cap(4, "ident");
    run(40, "R10 rerun"); cmp_wire(40, "R10 rerun");

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [7:0] ops [6] = '{8'h60, 8'hE3, 8'hA0, 8'hD5, 8'hC0, 8'h40};
      logic [7:0] c = ops[$urandom_range(0, 5)];
      int nb = $urandom_range(1, 10);
      int n = (c == 8'hA0) ? 16 : (c == 8'hD5) ? 40 : is_addr(c) ? 32 + 8*nb : 8;
      for (int i = 0; i < 16; i++) resp[i] = 8'($urandom);
      setup(c, 24'($urandom), n);
      if (c == 8'h40) load_out(nb);
      run(n, "rand");
      cmp_wire(n, "rand");
      if (c == 8'hC0) cmp_cap(nb, "rand");
      if (c == 8'hA0) begin rd(8'h20, b); chk(b == resp[1], "R8 rand status", b, resp[1]); end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule